// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block runs whole I2C memory transactions: a presence probe, a write that is prefixed by a register address, and a read that is prefixed by a register address. It sits above a bit-level line engine. It hands that engine one primitive at a time (START condition, STOP condition, byte write with the acknowledge sampled, byte read with an acknowledge bit to return) and chooses the next primitive from the result of the last one. The line timing belongs to the engine.

A host supplies the following, all sampled together on a start request:
- a 7-bit device address,
- a register address of zero up to `AB_MAX` bytes,
- a byte count,
- two mode bits: one picks a repeated START between the address phase and the read phase, the other turns on address folding for memories whose high address bits go in the device address.

Write data arrives on a valid/ready byte stream. Read data leaves on a second valid/ready stream, and the sequencer holds back the next byte read until the host has taken the previous byte. When a transaction ends, three registered status outputs describe it: a device NACK, an address NACK, and the number of data bytes that were NACKed during a write.

Top module: `i2c_mem_seq`

## Requirements
- R1: Op code 0 (probe) issues START, the device byte `{dev,0}` and STOP. `dev_nack` is 0 when that byte is ACKed and 1 when it is NACKed. Engine command codes: 0 START, 1 STOP, 2 write byte, 3 read byte.
- R2: On a write (op 1), a NACK on the device byte `{dev,0}` causes STOP to be issued next. The transaction then ends with `dev_nack`=1 and no address or data bytes are sent.
- R3: Register address bytes follow the device byte, most significant byte first, and there are exactly `addr_len` of them.
- R4: A NACK on any register address byte ends the transaction at once with `addr_nack`=1. No further byte and no STOP is issued.
- R5: During the data phase of a write, each NACKed byte adds one to `nack_cnt`. The remaining bytes are still sent, and STOP follows the last one.
- R6: On a read (op 2) with `addr_len`>0 and `rep_start`=0, the address phase is followed by STOP, then START, then the device byte `{dev,1}`.
- R7: With `rep_start`=1, the same read issues only START between the address phase and `{dev,1}`.
- R8: A read with `addr_len`=0 issues `{dev,1}` directly after the first START, with no `{dev,0}` and no address bytes.
- R9: A read issues `byte_cnt` byte reads and then STOP. The read command carries `eng_last`=1 (return NACK) only on the final byte and 0 (return ACK) on all earlier bytes. The bytes come out on `rd_data` in the order they were received.
- R10: With `ovf_en`=1, the device address used in every device byte is `dev | ((reg_addr >> 8*addr_len) & ovf_mask)`. The number of address bytes sent does not change.
- R11: A start request is accepted only while `busy`=0, and `busy` is high from the cycle after acceptance until the cycle of the `done` pulse. A start request that arrives while busy is ignored: it does not change the transaction in progress.
- R12: While `rd_valid`=1, `rd_data` holds steady and no read-byte command is issued until the host accepts the byte.
- R13: Write data is taken from the stream one byte per data byte, in stream order. `wr_ready` is high only while a data byte is due.
- R14: Only one engine command is outstanding at a time. `eng_valid` is a one-cycle pulse, and the next pulse comes only after `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request (accepted when idle) |
| op | input | 2 | 0 probe, 1 write, 2 read |
| dev_addr | input | 7 | 7-bit device address |
| reg_addr | input | AB_MAX*8 | Register address, right aligned |
| addr_len | input | clog2(AB_MAX+1) | Number of register address bytes |
| byte_cnt | input | CNT_W | Number of data bytes |
| rep_start | input | 1 | Repeated START instead of STOP+START before a read |
| ovf_en | input | 1 | Enable address folding into the device address |
| ovf_mask | input | 7 | Mask applied to the folded address bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| dev_nack | output | 1 | Device byte was NACKed |
| addr_nack | output | 1 | A register address byte was NACKed |
| nack_cnt | output | CNT_W | Count of NACKed write data bytes |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Write data byte due |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Host accepts read byte |
| eng_valid | output | 1 | Command pulse to the bit engine |
| eng_cmd | output | 2 | Command code (0 START, 1 STOP, 2 write, 3 read) |
| eng_byte | output | 8 | Byte to write |
| eng_last | output | 1 | On a read: 1 returns NACK, 0 returns ACK |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Written byte was NACKed |
| eng_rxbyte | input | 8 | Byte received by a read |

## Verification
The bench builds the block with its defaults, `AB_MAX`=4 and `CNT_W`=8. At these values every address length from zero to four bytes can be reached. At the full four-byte length, folding shifts the whole register address away, so the folded device address must come out unchanged. The 8-bit count leaves room for multi-byte writes where every data byte is NACKed, and for slow read handshakes that force the stall path.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int DEV_W = 7;

  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_STOP  = 2'd1,
    ENG_WRITE = 2'd2,
    ENG_READ  = 2'd3
  } eng_cmd_e;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } seq_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_DEVW,
    S_ADDR,
    S_MSTOP,
    S_MSTART,
    S_DEVR,
    S_WDATA,
    S_RDATA,
    S_STOP
  } seq_state_e;

endpackage

// File: rtl/i2c_seq_addr.sv
// Device-address folding and register-address byte selection.
module i2c_seq_addr #(
  parameter  int AB_MAX = 4,
  localparam int RA_W   = AB_MAX * 8,
  localparam int LEN_W  = $clog2(AB_MAX + 1)
) (
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [LEN_W-1:0] alen,
  input  logic [LEN_W-1:0] idx,
  input  logic [6:0]       dev,
  input  logic             ovf_en,
  input  logic [6:0]       ovf_mask,
  output logic [6:0]       eff_dev,
  output logic [7:0]       addr_byte
);

  logic [RA_W+7:0] above;
  logic [RA_W-1:0] sel;

  // Bits left over above the transmitted address bytes.
  assign above     = {8'h00, reg_addr} >> {alen, 3'b000};
  assign eff_dev   = dev | (ovf_en ? (above[6:0] & ovf_mask) : 7'h00);

  assign sel       = reg_addr >> {idx, 3'b000};
  assign addr_byte = sel[7:0];

endmodule

// File: rtl/i2c_seq_rdbuf.sv
// Single-entry holding register for the read stream.
module i2c_seq_rdbuf (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] din,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  input  logic       rd_ready
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else if (load) begin
      rd_valid <= 1'b1;
      rd_data  <= din;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq #(
  parameter  int AB_MAX = 4,
  parameter  int CNT_W  = 8,
  localparam int RA_W   = AB_MAX * 8,
  localparam int LEN_W  = $clog2(AB_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [6:0]       dev_addr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [LEN_W-1:0] addr_len,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             rep_start,
  input  logic             ovf_en,
  input  logic [6:0]       ovf_mask,
  output logic             busy,
  output logic             done,
  output logic             dev_nack,
  output logic             addr_nack,
  output logic [CNT_W-1:0] nack_cnt,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             eng_valid,
  output logic [1:0]       eng_cmd,
  output logic [7:0]       eng_byte,
  output logic             eng_last,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [7:0]       eng_rxbyte
);
  import i2c_seq_pkg::*;

  seq_state_e       state_q;
  logic [1:0]       op_q;
  logic [6:0]       dev_q;
  logic [RA_W-1:0]  ra_q;
  logic [LEN_W-1:0] alen_q;
  logic [LEN_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rem_q;
  logic             rep_q;
  logic             ovf_q;
  logic [6:0]       mask_q;
  logic             pend_q;

  logic [6:0]       eff_dev;
  logic [7:0]       addr_byte;
  logic             can_go;
  eng_cmd_e         cmd_c;
  logic [7:0]       byte_c;
  logic             last_c;
  logic             rd_load;

  i2c_seq_addr #(.AB_MAX(AB_MAX)) u_addr (
    .reg_addr (ra_q),
    .alen     (alen_q),
    .idx      (idx_q),
    .dev      (dev_q),
    .ovf_en   (ovf_q),
    .ovf_mask (mask_q),
    .eff_dev  (eff_dev),
    .addr_byte(addr_byte)
  );

  assign rd_load = pend_q && eng_done && (state_q == S_RDATA);

  i2c_seq_rdbuf u_rdbuf (
    .clk     (clk),
    .rst     (rst),
    .load    (rd_load),
    .din     (eng_rxbyte),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .rd_ready(rd_ready)
  );

  assign busy     = (state_q != S_IDLE);
  assign wr_ready = (state_q == S_WDATA) && !pend_q;

  // Command for the current step and whether it may be issued now.
  always_comb begin
    can_go = 1'b0;
    cmd_c  = ENG_START;
    byte_c = 8'h00;
    last_c = 1'b0;
    unique case (state_q)
      S_START, S_MSTART: begin can_go = 1'b1; cmd_c = ENG_START; end
      S_STOP, S_MSTOP:   begin can_go = 1'b1; cmd_c = ENG_STOP;  end
      S_DEVW: begin can_go = 1'b1; cmd_c = ENG_WRITE; byte_c = {eff_dev, 1'b0}; end
      S_DEVR: begin can_go = 1'b1; cmd_c = ENG_WRITE; byte_c = {eff_dev, 1'b1}; end
      S_ADDR: begin can_go = 1'b1; cmd_c = ENG_WRITE; byte_c = addr_byte; end
      S_WDATA: begin can_go = wr_valid; cmd_c = ENG_WRITE; byte_c = wr_data; end
      S_RDATA: begin
        can_go = !rd_valid;
        cmd_c  = ENG_READ;
        last_c = (rem_q == CNT_W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      pend_q    <= 1'b0;
      eng_valid <= 1'b0;
      eng_cmd   <= 2'd0;
      eng_byte  <= 8'h00;
      eng_last  <= 1'b0;
      done      <= 1'b0;
      dev_nack  <= 1'b0;
      addr_nack <= 1'b0;
      nack_cnt  <= '0;
      op_q      <= 2'd0;
      dev_q     <= 7'h00;
      ra_q      <= '0;
      alen_q    <= '0;
      idx_q     <= '0;
      cnt_q     <= '0;
      rem_q     <= '0;
      rep_q     <= 1'b0;
      ovf_q     <= 1'b0;
      mask_q    <= 7'h00;
    end else begin
      eng_valid <= 1'b0;
      done      <= 1'b0;
      if (state_q == S_IDLE) begin
        if (start) begin
          op_q      <= op;
          dev_q     <= dev_addr;
          ra_q      <= reg_addr;
          alen_q    <= addr_len;
          cnt_q     <= byte_cnt;
          rep_q     <= rep_start;
          ovf_q     <= ovf_en;
          mask_q    <= ovf_mask;
          dev_nack  <= 1'b0;
          addr_nack <= 1'b0;
          nack_cnt  <= '0;
          state_q   <= S_START;
        end
      end else if (!pend_q) begin
        if (can_go) begin
          eng_valid <= 1'b1;
          eng_cmd   <= cmd_c;
          eng_byte  <= byte_c;
          eng_last  <= last_c;
          pend_q    <= 1'b1;
        end
      end else if (eng_done) begin
        pend_q <= 1'b0;
        unique case (state_q)
          S_START: begin
            if (op_q == OP_READ && alen_q == '0) state_q <= S_DEVR;
            else                                 state_q <= S_DEVW;
          end
          S_DEVW: begin
            if (eng_nack) begin
              dev_nack <= 1'b1;
              state_q  <= S_STOP;
            end else if (op_q == OP_PROBE) begin
              state_q <= S_STOP;
            end else if (alen_q != '0) begin
              idx_q   <= LEN_W'(alen_q - 1'b1);
              state_q <= S_ADDR;
            end else begin
              rem_q   <= cnt_q;
              state_q <= (cnt_q == '0) ? S_STOP : S_WDATA;
            end
          end
          S_ADDR: begin
            if (eng_nack) begin
              addr_nack <= 1'b1;
              done      <= 1'b1;
              state_q   <= S_IDLE;
            end else if (idx_q != '0) begin
              idx_q <= LEN_W'(idx_q - 1'b1);
            end else if (op_q == OP_WRITE) begin
              rem_q   <= cnt_q;
              state_q <= (cnt_q == '0) ? S_STOP : S_WDATA;
            end else begin
              state_q <= rep_q ? S_MSTART : S_MSTOP;
            end
          end
          S_MSTOP:  state_q <= S_MSTART;
          S_MSTART: state_q <= S_DEVR;
          S_DEVR: begin
            rem_q   <= cnt_q;
            state_q <= (cnt_q == '0) ? S_STOP : S_RDATA;
          end
          S_WDATA: begin
            if (eng_nack) nack_cnt <= nack_cnt + 1'b1;
            rem_q <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) state_q <= S_STOP;
          end
          S_RDATA: begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) state_q <= S_STOP;
          end
          S_STOP: begin
            done    <= 1'b1;
            state_q <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_mem_seq_chk.sv
module i2c_mem_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       eng_valid,
  input logic [1:0] eng_cmd,
  input logic       eng_done
);

  logic outst;

  always_ff @(posedge clk) begin
    if (rst)            outst <= 1'b0;
    else if (eng_valid) outst <= 1'b1;
    else if (eng_done)  outst <= 1'b0;
  end

  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_no_read_stalled_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && eng_valid) |-> (eng_cmd != 2'd3));

  assert_wr_ready_busy_R13: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> busy);

  assert_single_pulse_R14: assert property (@(posedge clk) disable iff (rst)
    eng_valid |=> !eng_valid);

  assert_one_outstanding_R14: assert property (@(posedge clk) disable iff (rst)
    eng_valid |-> !outst);

endmodule

bind i2c_mem_seq i2c_mem_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .wr_ready (wr_ready),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .eng_valid(eng_valid),
  .eng_cmd  (eng_cmd),
  .eng_done (eng_done)
);

// File: tb/test_i2c_mem_seq.sv
`timescale 1ns/1ps
module test_i2c_mem_seq;

  localparam int AB_MAX = 4;
  localparam int CNT_W  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [6:0]  dev_addr = 7'h00;
  logic [31:0] reg_addr = 32'h0;
  logic [2:0]  addr_len = 3'd0;
  logic [7:0]  byte_cnt = 8'd0;
  logic        rep_start = 1'b0;
  logic        ovf_en = 1'b0;
  logic [6:0]  ovf_mask = 7'h00;
  logic        busy, done, dev_nack, addr_nack;
  logic [7:0]  nack_cnt;
  logic [7:0]  wr_data = 8'h30;
  logic        wr_valid = 1'b1;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        rd_ready;
  logic        eng_valid;
  logic [1:0]  eng_cmd;
  logic [7:0]  eng_byte;
  logic        eng_last;
  logic        eng_done;
  logic        eng_nack;
  logic [7:0]  eng_rxbyte;

  always #2 clk = ~clk;

  i2c_mem_seq #(.AB_MAX(AB_MAX), .CNT_W(CNT_W)) i_i2c_mem_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .addr_len(addr_len), .byte_cnt(byte_cnt),
    .rep_start(rep_start), .ovf_en(ovf_en), .ovf_mask(ovf_mask),
    .busy(busy), .done(done), .dev_nack(dev_nack), .addr_nack(addr_nack),
    .nack_cnt(nack_cnt), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .eng_valid(eng_valid), .eng_cmd(eng_cmd),
    .eng_byte(eng_byte), .eng_last(eng_last), .eng_done(eng_done),
    .eng_nack(eng_nack), .eng_rxbyte(eng_rxbyte)
  );

  int total = 0;
  int bad   = 0;
  string cur_tag = "R14";

  logic [9:0] expq[$];
  logic [7:0] rdq[$];
  logic [15:0] nv_cur = 16'h0;
  int word = 0;
  int rdord = 0;
  int wr_idx = 0;
  int rd_seen = 0;
  bit slow = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R14 watchdog expired: actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  // Engine and device model plus command scoreboard monitor.
  initial begin
    logic [9:0] got;
    logic [9:0] ex;
    logic       nk;
    logic [7:0] rx;
    eng_done   = 1'b0;
    eng_nack   = 1'b0;
    eng_rxbyte = 8'h00;
    forever begin
      @(negedge clk);
      if (eng_valid) begin
        got = {eng_cmd, (eng_cmd == 2'd3) ? {7'h00, eng_last} :
                        (eng_cmd == 2'd2) ? eng_byte : 8'h00};
        if (expq.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected engine command", 32'(got), 32'h3ff);
        end else begin
          ex = expq.pop_front();
          chk(got == ex, cur_tag, "engine command", 32'(got), 32'(ex));
        end
        nk = 1'b0;
        rx = 8'h00;
        if (eng_cmd == 2'd3) begin
          chk(rd_valid == 1'b0, "R12", "read issued with byte held", 32'(rd_valid), 0);
          rx = 8'(8'hA0 + rdord);
          rdord++;
        end
        if (eng_cmd == 2'd2) begin
          nk = (word < 16) ? nv_cur[word] : 1'b0;
          word++;
        end
        repeat (2) @(negedge clk);
        eng_done   = 1'b1;
        eng_nack   = nk;
        eng_rxbyte = rx;
        @(negedge clk);
        eng_done = 1'b0;
        eng_nack = 1'b0;
      end
    end
  end

  // Write stream feeder.
  initial begin
    bit take;
    forever begin
      @(negedge clk);
      take = wr_valid && wr_ready;
      @(posedge clk);
      #1;
      if (take) begin
        wr_idx++;
        wr_data = 8'(8'h30 + wr_idx);
      end
    end
  end

  // Read stream monitor.
  initial begin
    bit acc;
    int phase;
    logic [7:0] e;
    phase = 0;
    rd_ready = 1'b1;
    forever begin
      @(negedge clk);
      acc = rd_valid && rd_ready;
      if (acc) begin
        if (rdq.size() == 0) begin
          chk(1'b0, "R9", "unexpected read byte", 32'(rd_data), 0);
        end else begin
          e = rdq.pop_front();
          chk(rd_data == e, "R9", "read data", 32'(rd_data), 32'(e));
        end
        rd_seen++;
      end
      @(posedge clk);
      #1;
      phase++;
      rd_ready = slow ? (phase % 4 == 3) : 1'b1;
    end
  end

  function automatic void push(input logic [1:0] c, input logic [7:0] b);
    expq.push_back({c, b});
  endfunction

  task automatic run_txn(input string tag, input logic [1:0] t_op,
                         input logic [6:0] dev, input logic [31:0] ra,
                         input int alen, input int cnt, input bit rep,
                         input bit ovf, input logic [6:0] mask,
                         input logic [15:0] nv, input bit t_slow,
                         input bit inject);
    int ord;
    int e_nk;
    int e_wr;
    int e_rd;
    bit e_dev;
    bit e_addr;
    bit abort;
    bit seen;
    int k;
    logic [6:0] eff;
    logic [63:0] wide;
    wide  = 64'(ra) >> (8 * alen);
    eff   = dev | (ovf ? (wide[6:0] & mask) : 7'h00);
    ord   = 0; e_nk = 0; e_wr = 0; e_rd = 0;
    e_dev = 0; e_addr = 0; abort = 0;
    push(2'd0, 8'h00);
    if (t_op == 2'd2 && alen == 0) begin
      push(2'd2, {eff, 1'b1});
      ord++;
      for (int j = 0; j < cnt; j++) begin
        push(2'd3, {7'h00, 1'(j == cnt - 1)});
        rdq.push_back(8'(8'hA0 + j));
      end
      e_rd = cnt;
      push(2'd1, 8'h00);
    end else begin
      push(2'd2, {eff, 1'b0});
      if (nv[ord]) begin
        e_dev = 1;
        push(2'd1, 8'h00);
      end else if (t_op == 2'd0) begin
        push(2'd1, 8'h00);
      end else begin
        ord++;
        for (int i = alen - 1; i >= 0; i--) begin
          push(2'd2, 8'(ra >> (8 * i)));
          if (nv[ord]) begin
            abort  = 1;
            e_addr = 1;
            break;
          end
          ord++;
        end
        if (!abort) begin
          if (t_op == 2'd1) begin
            for (int j = 0; j < cnt; j++) begin
              push(2'd2, 8'(8'h30 + j));
              if (nv[ord]) e_nk++;
              ord++;
            end
            e_wr = cnt;
            push(2'd1, 8'h00);
          end else begin
            if (!rep) push(2'd1, 8'h00);
            push(2'd0, 8'h00);
            push(2'd2, {eff, 1'b1});
            for (int j = 0; j < cnt; j++) begin
              push(2'd3, {7'h00, 1'(j == cnt - 1)});
              rdq.push_back(8'(8'hA0 + j));
            end
            e_rd = cnt;
            push(2'd1, 8'h00);
          end
        end
      end
    end

    @(negedge clk);
    cur_tag = tag;
    nv_cur  = nv;
    word    = 0;
    rdord   = 0;
    wr_idx  = 0;
    wr_data = 8'h30;
    rd_seen = 0;
    slow    = t_slow;
    op = t_op; dev_addr = dev; reg_addr = ra; addr_len = 3'(alen);
    byte_cnt = 8'(cnt); rep_start = rep; ovf_en = ovf; ovf_mask = mask;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after accept", 32'(busy), 1);
    seen = 0;
    k = 0;
    while (!seen) begin
      @(negedge clk);
      start = 1'b0;
      if (done) seen = 1;
      k++;
      if (inject && k == 4) begin
        op = 2'd0; dev_addr = 7'h7F; start = 1'b1;
      end
    end
    start = 1'b0;
    chk(busy == 1'b0, "R11", "busy clear at done", 32'(busy), 0);
    while (rd_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R11", "idle after done", 32'(busy), 0);
    chk(dev_nack == e_dev, tag, "dev_nack", 32'(dev_nack), 32'(e_dev));
    chk(addr_nack == e_addr, tag, "addr_nack", 32'(addr_nack), 32'(e_addr));
    chk(nack_cnt == 8'(e_nk), tag, "nack_cnt", 32'(nack_cnt), 32'(e_nk));
    chk(wr_idx == e_wr, "R13", "write bytes taken", 32'(wr_idx), 32'(e_wr));
    chk(rd_seen == e_rd, "R9", "read bytes delivered", 32'(rd_seen), 32'(e_rd));
    chk(expq.size() == 0, tag, "commands left over", 32'(expq.size()), 0);
    expq.delete();
    rdq.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11", "reset busy", 32'(busy), 0);
    chk(eng_valid == 1'b0, "R14", "reset eng_valid", 32'(eng_valid), 0);
    chk(rd_valid == 1'b0, "R12", "reset rd_valid", 32'(rd_valid), 0);
    chk(wr_ready == 1'b0, "R13", "reset wr_ready", 32'(wr_ready), 0);

    run_txn("R1",    2'd0, 7'h50, 32'h0,        0, 0, 0, 0, 7'h00, 16'h0000, 0, 0);
    run_txn("R1",    2'd0, 7'h2C, 32'h0,        0, 0, 0, 0, 7'h00, 16'h0001, 0, 0);
    run_txn("R2",    2'd1, 7'h50, 32'h1234,     2, 3, 0, 0, 7'h00, 16'h0001, 0, 0);
    run_txn("R3/R5", 2'd1, 7'h50, 32'h1234,     2, 3, 0, 0, 7'h00, 16'h0010, 0, 1);
    run_txn("R4",    2'd1, 7'h51, 32'h00ABCDEF, 3, 2, 0, 0, 7'h00, 16'h0004, 0, 0);
    run_txn("R6",    2'd2, 7'h51, 32'h07,       1, 3, 0, 0, 7'h00, 16'h0000, 1, 0);
    run_txn("R7",    2'd2, 7'h52, 32'hBEEF,     2, 2, 1, 0, 7'h00, 16'h0000, 0, 1);
    run_txn("R8",    2'd2, 7'h53, 32'h0,        0, 1, 0, 0, 7'h00, 16'h0000, 0, 0);
    run_txn("R10",   2'd2, 7'h50, 32'h3A5,      1, 2, 0, 1, 7'h07, 16'h0000, 1, 0);
    run_txn("R10",   2'd1, 7'h50, 32'h89ABCDEF, 4, 1, 0, 1, 7'h7F, 16'h0020, 0, 0);
    run_txn("R5",    2'd1, 7'h44, 32'h0,        0, 3, 0, 0, 7'h00, 16'h000E, 0, 0);
    run_txn("R13",   2'd1, 7'h45, 32'h9,        1, 0, 0, 0, 7'h00, 16'h0000, 0, 0);
    run_txn("R9",    2'd2, 7'h46, 32'h9,        1, 0, 1, 0, 7'h00, 16'h0000, 0, 0);
    run_txn("R9",    2'd2, 7'h47, 32'h1,        1, 5, 0, 0, 7'h00, 16'h0000, 1, 0);

    finish_run();
  end

endmodule